// File: doc/BRIEF.md
# Framebuffer Geometry and Start-Address Unit

This unit takes a requested display mode (horizontal and vertical resolution, colour depth, virtual line width, panning offsets) and the size of video memory. It cleans the mode values into a legal range and works out two numbers the display fetch logic needs: the number of bytes from one scan line to the next (the stride), and the byte address of the first visible pixel (the start address). If the visible window, placed at the requested panning position, would run past the end of video memory, the unit moves the window back. It first drops the vertical offset to zero. If the window still does not fit, it also drops the horizontal offset to zero.

A request enters through a valid/ready handshake. All mode values and the memory size are captured on the accepting edge, so the requester can change its inputs at once. The arithmetic takes four multiplications, which share one multiplier, one per cycle, and then a fit check. The result appears on a valid/ready output port.

Back-pressure rules:
- The result stays valid and every output holds its value until the consumer raises `res_ready`.
- A new request is not accepted while a computation is running or while a result is waiting.
- After the result handshake, the outputs keep their values until the next result is produced.

Top module: `geo_unit`

## Requirements
- R1: The returned horizontal resolution is the request rounded down to a multiple of 8. A result of 0 becomes 8.
- R2: The returned virtual width is first limited to at most MAX_X (1920). It is then raised to at least the returned horizontal resolution.
- R3: The returned horizontal offset is limited to at most 1920. The returned vertical offset is limited to at most 1600.
- R4: The returned vertical resolution is 1 when the request is 0, and it is limited to at most 1600.
- R5: At a depth of 4 the stride is the virtual width divided by 8. At any other depth it is the virtual width times (depth integer-divided by 8), so depth 15 gives 1 byte per pixel.
- R6: The start address is vertical offset times stride plus the horizontal byte offset. The horizontal byte offset is the horizontal offset divided by 8 at depth 4, and otherwise the horizontal offset times (depth/8).
- R7: If the start address plus vertical resolution times stride is strictly greater than the memory size, the returned vertical offset is 0 and the start address is recomputed with it.
- R8: If the recomputed window still exceeds memory, the start address and the returned horizontal offset are both 0.
- R9: `fmt_o` encodes the depth as follows: 4→0, 8→1, 15→2, 16→3, 24→4, 32→5. Any other depth gives 1.
- R10: `req_ready` is high only when the unit is idle and no result is waiting. `res_valid` rises on the 5th rising edge after the accepting edge. It stays high with unchanged outputs until the edge where `res_ready` is high.
- R11: After reset, every result output is 0, `res_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can take a request |
| xres_i | input | W | Requested horizontal resolution |
| yres_i | input | W | Requested vertical resolution |
| bpp_i | input | W | Requested depth in bits per pixel |
| vwidth_i | input | W | Requested virtual line width in pixels |
| xoff_i | input | W | Requested horizontal panning offset |
| yoff_i | input | W | Requested vertical panning offset |
| vram_bytes_i | input | SW | Video memory size in bytes |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| xres_o | output | W | Cleaned horizontal resolution |
| yres_o | output | W | Cleaned vertical resolution |
| vwidth_o | output | W | Cleaned virtual width |
| xoff_o | output | W | Final horizontal offset |
| yoff_o | output | W | Final vertical offset |
| fmt_o | output | 3 | Pixel format code |
| stride_o | output | SW | Bytes per scan line |
| start_o | output | SW | Byte address of the first visible pixel |

## Verification
The hardest case to reach is the second fallback step. The memory size must be large enough to be a realistic configuration, yet smaller than the span of visible lines plus the horizontal byte offset. It must also be smaller than the full window, so that the first step fires. The bench does not pick memory sizes at random. It works out the span for the chosen mode and sets the memory size a few bytes on either side of the two thresholds. This makes three outcomes appear next to each other: no fallback, the first step only, and both steps. The bench also holds `res_ready` low for several cycles and keeps `req_valid` high while the unit is busy, to exercise the hold and refusal rules.

// File: rtl/geo_pkg.sv
package geo_pkg;
  typedef enum logic [2:0] {
    PF_4  = 3'd0,
    PF_8  = 3'd1,
    PF_15 = 3'd2,
    PF_16 = 3'd3,
    PF_24 = 3'd4,
    PF_32 = 3'd5
  } pix_fmt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STRIDE,
    ST_XBYTE,
    ST_YROW,
    ST_SPAN,
    ST_CHECK,
    ST_HOLD
  } geo_state_e;
endpackage

// File: rtl/geo_clamp.sv
module geo_clamp #(
  parameter int W     = 16,
  parameter int MAX_X = 1920,
  parameter int MAX_Y = 1600
) (
  input  logic [W-1:0] xres_raw,
  input  logic [W-1:0] yres_raw,
  input  logic [W-1:0] vw_raw,
  input  logic [W-1:0] xoff_raw,
  input  logic [W-1:0] yoff_raw,
  output logic [W-1:0] xres_c,
  output logic [W-1:0] yres_c,
  output logic [W-1:0] vw_c,
  output logic [W-1:0] xoff_c,
  output logic [W-1:0] yoff_c
);
  localparam logic [W-1:0] LIM_X = W'(MAX_X);
  localparam logic [W-1:0] LIM_Y = W'(MAX_Y);

  logic [W-1:0] x_round;
  logic [W-1:0] vw_cap;

  always_comb begin
    x_round = {xres_raw[W-1:3], 3'b000};
    xres_c  = (x_round == '0) ? W'(8) : x_round;
    vw_cap  = (vw_raw > LIM_X) ? LIM_X : vw_raw;
    vw_c    = (vw_cap < xres_c) ? xres_c : vw_cap;
    xoff_c  = (xoff_raw > LIM_X) ? LIM_X : xoff_raw;
    yoff_c  = (yoff_raw > LIM_Y) ? LIM_Y : yoff_raw;
    if (yres_raw == '0)       yres_c = W'(1);
    else if (yres_raw > LIM_Y) yres_c = LIM_Y;
    else                      yres_c = yres_raw;
  end
endmodule

// File: rtl/geo_pixfmt.sv
module geo_pixfmt
  import geo_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] bpp,
  output pix_fmt_e     fmt,
  output logic         nibble_mode,
  output logic [W-1:0] bytes_pp
);
  always_comb begin
    bytes_pp    = bpp >> 3;
    nibble_mode = (bpp == W'(4));
    unique case (bpp)
      W'(4):   fmt = PF_4;
      W'(15):  fmt = PF_15;
      W'(16):  fmt = PF_16;
      W'(24):  fmt = PF_24;
      W'(32):  fmt = PF_32;
      default: fmt = PF_8;
    endcase
  end
endmodule

// File: rtl/geo_mul.sv
module geo_mul #(
  parameter int AW = 16,
  parameter int BW = 32
) (
  input  logic [AW-1:0]    op_a,
  input  logic [BW-1:0]    op_b,
  output logic [AW+BW-1:0] prod
);
  assign prod = {{BW{1'b0}}, op_a} * {{AW{1'b0}}, op_b};
endmodule

// File: rtl/geo_unit.sv
module geo_unit
  import geo_pkg::*;
#(
  parameter int W     = 16,
  parameter int SW    = 32,
  parameter int MAX_X = 1920,
  parameter int MAX_Y = 1600
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [W-1:0]  xres_i,
  input  logic [W-1:0]  yres_i,
  input  logic [W-1:0]  bpp_i,
  input  logic [W-1:0]  vwidth_i,
  input  logic [W-1:0]  xoff_i,
  input  logic [W-1:0]  yoff_i,
  input  logic [SW-1:0] vram_bytes_i,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [W-1:0]  xres_o,
  output logic [W-1:0]  yres_o,
  output logic [W-1:0]  vwidth_o,
  output logic [W-1:0]  xoff_o,
  output logic [W-1:0]  yoff_o,
  output logic [2:0]    fmt_o,
  output logic [SW-1:0] stride_o,
  output logic [SW-1:0] start_o
);
  localparam int PW = W + SW;

  geo_state_e state_q;

  logic [W-1:0]  xres_c, yres_c, vw_c, xoff_c, yoff_c, bpb_c;
  pix_fmt_e      fmt_c;
  logic          nib_c;

  logic [W-1:0]  xres_q, yres_q, vw_q, xoff_q, yoff_q, bpb_q;
  pix_fmt_e      fmt_q;
  logic          nib_q;
  logic [SW-1:0] vram_q;
  logic [SW-1:0] stride_q;
  logic [PW-1:0] xb_q, yrow_q, span_q;

  logic [W-1:0]  mul_a;
  logic [SW-1:0] mul_b;
  logic [PW-1:0] mul_p;
  logic [PW:0]   win_full, win_noy, vram_ext;

  geo_clamp #(.W(W), .MAX_X(MAX_X), .MAX_Y(MAX_Y)) u_clamp (
    .xres_raw(xres_i), .yres_raw(yres_i), .vw_raw(vwidth_i),
    .xoff_raw(xoff_i), .yoff_raw(yoff_i),
    .xres_c(xres_c), .yres_c(yres_c), .vw_c(vw_c),
    .xoff_c(xoff_c), .yoff_c(yoff_c)
  );

  geo_pixfmt #(.W(W)) u_fmt (
    .bpp(bpp_i), .fmt(fmt_c), .nibble_mode(nib_c), .bytes_pp(bpb_c)
  );

  geo_mul #(.AW(W), .BW(SW)) u_mul (.op_a(mul_a), .op_b(mul_b), .prod(mul_p));

  assign req_ready = (state_q == ST_IDLE);
  assign res_valid = (state_q == ST_HOLD);

  // Operand steering for the single shared multiplier.
  always_comb begin
    mul_a = '0;
    mul_b = '0;
    unique case (state_q)
      ST_STRIDE: begin
        mul_a = nib_q ? (vw_q >> 3) : vw_q;
        mul_b = nib_q ? SW'(1) : {{(SW-W){1'b0}}, bpb_q};
      end
      ST_XBYTE: begin
        mul_a = nib_q ? (xoff_q >> 3) : xoff_q;
        mul_b = nib_q ? SW'(1) : {{(SW-W){1'b0}}, bpb_q};
      end
      ST_YROW: begin
        mul_a = yoff_q;
        mul_b = stride_q;
      end
      ST_SPAN: begin
        mul_a = yres_q;
        mul_b = stride_q;
      end
      default: ;
    endcase
  end

  assign win_full = {1'b0, yrow_q} + {1'b0, xb_q} + {1'b0, span_q};
  assign win_noy  = {1'b0, xb_q} + {1'b0, span_q};
  assign vram_ext = {{(PW+1-SW){1'b0}}, vram_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      xres_q   <= '0; yres_q <= '0; vw_q <= '0; xoff_q <= '0; yoff_q <= '0;
      bpb_q    <= '0; fmt_q  <= PF_8; nib_q <= 1'b0; vram_q <= '0;
      stride_q <= '0; xb_q   <= '0; yrow_q <= '0; span_q <= '0;
      xres_o   <= '0; yres_o <= '0; vwidth_o <= '0; xoff_o <= '0; yoff_o <= '0;
      fmt_o    <= '0; stride_o <= '0; start_o <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          xres_q <= xres_c; yres_q <= yres_c; vw_q <= vw_c;
          xoff_q <= xoff_c; yoff_q <= yoff_c;
          bpb_q  <= bpb_c;  fmt_q  <= fmt_c;  nib_q <= nib_c;
          vram_q <= vram_bytes_i;
          state_q <= ST_STRIDE;
        end
        ST_STRIDE: begin
          stride_q <= mul_p[SW-1:0];
          state_q  <= ST_XBYTE;
        end
        ST_XBYTE: begin
          xb_q    <= mul_p;
          state_q <= ST_YROW;
        end
        ST_YROW: begin
          yrow_q  <= mul_p;
          state_q <= ST_SPAN;
        end
        ST_SPAN: begin
          span_q  <= mul_p;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          xres_o   <= xres_q;
          yres_o   <= yres_q;
          vwidth_o <= vw_q;
          fmt_o    <= fmt_q;
          stride_o <= stride_q;
          if (win_full > vram_ext) begin
            yoff_o <= '0;
            if (win_noy > vram_ext) begin
              xoff_o  <= '0;
              start_o <= '0;
            end else begin
              xoff_o  <= xoff_q;
              start_o <= xb_q[SW-1:0];
            end
          end else begin
            yoff_o  <= yoff_q;
            xoff_o  <= xoff_q;
            start_o <= yrow_q[SW-1:0] + xb_q[SW-1:0];
          end
          state_q <= ST_HOLD;
        end
        ST_HOLD: if (res_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/geo_unit_chk.sv
module geo_unit_chk #(
  parameter int W     = 16,
  parameter int SW    = 32,
  parameter int MAX_X = 1920,
  parameter int MAX_Y = 1600
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          res_valid,
  input logic          res_ready,
  input logic [W-1:0]  xres_o,
  input logic [W-1:0]  yres_o,
  input logic [W-1:0]  vwidth_o,
  input logic [W-1:0]  xoff_o,
  input logic [W-1:0]  yoff_o,
  input logic [SW-1:0] stride_o,
  input logic [SW-1:0] start_o
);
  a_r10_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && res_valid));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(start_o) && $stable(stride_o)
                                   && $stable(xoff_o) && $stable(yoff_o)));

  a_r1_xres_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (xres_o[2:0] == 3'b000 && xres_o != '0));

  a_r2_vwidth_floor: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (vwidth_o >= xres_o));

  a_r3_offset_caps: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (xoff_o <= W'(MAX_X) && yoff_o <= W'(MAX_Y)));

  a_r4_yres_range: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (yres_o >= W'(1) && yres_o <= W'(MAX_Y)));
endmodule

bind geo_unit geo_unit_chk #(.W(W), .SW(SW), .MAX_X(MAX_X), .MAX_Y(MAX_Y)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .res_valid(res_valid),
  .res_ready(res_ready), .xres_o(xres_o), .yres_o(yres_o), .vwidth_o(vwidth_o),
  .xoff_o(xoff_o), .yoff_o(yoff_o), .stride_o(stride_o), .start_o(start_o)
);

// File: tb/geo_unit_bench.sv
module geo_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        res_ready = 1'b0;
  logic [15:0] xres_i = '0, yres_i = '0, bpp_i = '0, vwidth_i = '0, xoff_i = '0, yoff_i = '0;
  logic [31:0] vram_bytes_i = '0;
  logic        req_ready, res_valid;
  logic [15:0] xres_o, yres_o, vwidth_o, xoff_o, yoff_o;
  logic [2:0]  fmt_o;
  logic [31:0] stride_o, start_o;

  always #10 clk = ~clk;

  geo_unit u_geo_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .xres_i(xres_i), .yres_i(yres_i), .bpp_i(bpp_i), .vwidth_i(vwidth_i),
    .xoff_i(xoff_i), .yoff_i(yoff_i), .vram_bytes_i(vram_bytes_i),
    .res_valid(res_valid), .res_ready(res_ready),
    .xres_o(xres_o), .yres_o(yres_o), .vwidth_o(vwidth_o), .xoff_o(xoff_o),
    .yoff_o(yoff_o), .fmt_o(fmt_o), .stride_o(stride_o), .start_o(start_o)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // Reference model state
  int     m_cnt = 0;
  bit     m_valid = 0;
  bit     m_acc = 0;
  longint p_xr, p_yr, p_vw, p_xo, p_yo, p_fmt, p_str, p_st;
  longint e_xr = 0, e_yr = 0, e_vw = 0, e_xo = 0, e_yo = 0, e_fmt = 0, e_str = 0, e_st = 0;

  task automatic model_compute(input longint xr, yr, bp, vw, xo, yo, vram);
    longint bpb, xb, st;
    xr = xr - (xr % 8);
    if (xr == 0) xr = 8;
    if (vw > 1920) vw = 1920;
    if (vw < xr) vw = xr;
    if (xo > 1920) xo = 1920;
    if (yo > 1600) yo = 1600;
    if (yr == 0) yr = 1;
    if (yr > 1600) yr = 1600;
    bpb = bp / 8;
    if (bp == 4) begin p_str = vw / 8; xb = xo / 8; end
    else begin p_str = vw * bpb; xb = xo * bpb; end
    st = yo * p_str + xb;
    if (st + yr * p_str > vram) begin
      yo = 0;
      st = xb;
      if (st + yr * p_str > vram) begin st = 0; xo = 0; end
    end
    case (bp)
      4: p_fmt = 0;  15: p_fmt = 2;  16: p_fmt = 3;
      24: p_fmt = 4; 32: p_fmt = 5;  default: p_fmt = 1;
    endcase
    p_xr = xr; p_yr = yr; p_vw = vw; p_xo = xo; p_yo = yo; p_st = st;
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic tick();
    bit rdy;
    @(posedge clk);
    cycles++;
    m_acc = 0;
    if (!rst_n) begin
      m_cnt = 0; m_valid = 0;
      e_xr = 0; e_yr = 0; e_vw = 0; e_xo = 0; e_yo = 0; e_fmt = 0; e_str = 0; e_st = 0;
    end else begin
      rdy = (m_cnt == 0) && !m_valid;
      if (m_valid && res_ready) m_valid = 0;
      if (rdy && req_valid) begin
        model_compute(xres_i, yres_i, bpp_i, vwidth_i, xoff_i, yoff_i, vram_bytes_i);
        m_cnt = 5;
        m_acc = 1;
      end else if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_valid = 1;
          e_xr = p_xr; e_yr = p_yr; e_vw = p_vw; e_xo = p_xo; e_yo = p_yo;
          e_fmt = p_fmt; e_str = p_str; e_st = p_st;
        end
      end
    end
    @(negedge clk);
    // Every clock: handshake (R10, R11) and result fields (held between results)
    chk("R10/R11 req_ready", req_ready, (m_cnt == 0) && !m_valid);
    chk("R10 res_valid", res_valid, m_valid);
    chk("R1 xres", xres_o, e_xr);
    chk("R4 yres", yres_o, e_yr);
    chk("R2 vwidth", vwidth_o, e_vw);
    chk("R3,R8 xoff", xoff_o, e_xo);
    chk("R3,R7 yoff", yoff_o, e_yo);
    chk("R9 fmt", fmt_o, e_fmt);
    chk("R5 stride", stride_o, e_str);
    chk("R6,R7,R8 start", start_o, e_st);
    if (cycles > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic run(input int xr, yr, bp, vw, xo, yo, input longint vram, input int hold);
    @(negedge clk);
    req_valid = 1; xres_i = 16'(xr); yres_i = 16'(yr); bpp_i = 16'(bp);
    vwidth_i = 16'(vw); xoff_i = 16'(xo); yoff_i = 16'(yo); vram_bytes_i = 32'(vram);
    do tick(); while (!m_acc);
    // Keep offering garbage while busy: must be refused (R10) and not disturb the latched values
    xres_i = 16'hFFFF; yres_i = 16'h0; bpp_i = 16'd7; xoff_i = 16'hABCD;
    vram_bytes_i = 32'd1;
    tick();
    req_valid = 0;
    while (!m_valid) tick();
    for (int i = 0; i < hold; i++) tick();
    res_ready = 1;
    tick();
    res_ready = 0;
    tick();
  endtask

  initial begin
    for (int i = 0; i < 3; i++) tick();   // R11: reset values compared each clock
    rst_n = 1;
    tick();
    // R6 plain 8 bpp window
    run(640, 480, 8, 640, 16, 100, 64'd16777216, 2);
    // R5 nibble mode stride and start
    run(800, 600, 4, 1024, 37, 5, 64'd4194304, 0);
    // R5 15 bpp uses one byte per pixel
    run(1024, 768, 15, 1024, 10, 3, 64'd8388608, 1);
    run(1280, 1024, 16, 1300, 9, 7, 64'd16777216, 0);
    run(1920, 1200, 24, 1920, 3, 2, 64'd16777216, 0);
    run(640, 400, 32, 2000, 100, 50, 64'd16777216, 3);
    // R9 odd depth -> 8-bit format, stride uses depth/8
    run(320, 200, 12, 320, 4, 4, 64'd1048576, 0);
    // R1 rounding and zero
    run(5, 10, 8, 0, 0, 0, 64'd65536, 0);
    run(645, 10, 8, 0, 0, 0, 64'd65536, 0);
    run(0, 10, 8, 0, 0, 0, 64'd65536, 0);
    // R2 virtual width over cap, and below xres with xres above cap
    run(2048, 10, 8, 5000, 0, 0, 64'd16777216, 0);
    run(640, 10, 8, 100, 0, 0, 64'd65536, 0);
    // R3 and R4 caps
    run(640, 0, 8, 640, 3000, 2000, 64'd16777216, 0);
    run(640, 5000, 8, 640, 1921, 1601, 64'd16777216, 0);
    // R7 / R8 thresholds: span = 640*480 = 307200, xbytes = 16, yrow = 6400
    run(640, 480, 8, 640, 16, 10, 64'd313616, 0);  // exactly fits: no fallback
    run(640, 480, 8, 640, 16, 10, 64'd313615, 0);  // R7 step one
    run(640, 480, 8, 640, 16, 10, 64'd307216, 0);  // R7 fits after step one
    run(640, 480, 8, 640, 16, 10, 64'd307215, 0);  // R8 step two
    run(800, 600, 32, 800, 1920, 1600, 64'd1000, 1); // R8 huge window
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule